// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the processor-side engine for a bus on which the low address bits and the data share one set of lines. The core presents a transfer request: memory read, memory write, I/O read, I/O write or interrupt acknowledge. The request carries a 20-bit address and write data. The block then runs a bus cycle of four clock phases. Wait phases are stretched in while the external ready input is low. The block returns read data, or the interrupt vector, with a one-cycle completion pulse.

During the first phase the block places the address on the shared lines and pulses the address-latch strobe. External logic catches the address with that strobe. From the second phase the shared lines carry data: the block drives them for writes and releases them for reads. The read, write and acknowledge strobes are active low and are held through the wait phases, and so is the data-enable output, which gates an external transceiver. The direction output sets which way that transceiver points.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset the block is idle: `addr_strobe`=0, `rd_n`=`wr_n`=`ack_n`=`den_n`=1, `bus_oe`=0, `done`=0, `req_ready`=1.
- R2: A request with a legal kind code, given while `req_ready`=1, starts phase one in the next cycle. In phase one `addr_strobe`=1, all three command strobes and `den_n` are high, and for all kinds except acknowledge `bus_oe`=1 with `bus_out` equal to the request address.
- R3: Kind codes are 0 memory read, 1 memory write, 2 I/O read, 3 I/O write, 4 acknowledge. `io_sel` is 1 for codes 2 and 3 and 0 otherwise. `dir_tx` is 1 for codes 1 and 3 and 0 otherwise. Both hold steady from phase one through phase four.
- R4: In phase two `addr_strobe`=0 and `den_n`=0, and exactly one command strobe is low: `wr_n` for writes, `ack_n` for acknowledge, `rd_n` otherwise. A write drives `bus_out` = {address[19:16], write data} with `bus_oe`=1. A read floats the bus (`bus_oe`=0).
- R5: Ready is sampled at the clock edge that ends phase two and at the edge that ends each wait phase. Each low sample adds one wait phase in which strobes and `den_n` stay active. A cycle with n low samples lasts 4+n clocks, with `done` high only in its last clock.
- R6: For reads, `bus_in` is captured at the edge that enters phase four and shown on `rdata` while `done`=1.
- R7: In phase four all command strobes and `den_n` are high and `done`=1 for exactly that one clock.
- R8: An acknowledge cycle never drives the bus (`bus_oe`=0 throughout). Its vector is the low 8 bits of `bus_in`, zero-extended on `rdata`.
- R9: `req_ready` is 1 only while idle or in phase four. A request accepted in phase four starts phase one in the very next clock with no idle gap.
- R10: Kind codes 5, 6 and 7 are ignored: the block stays idle, with no address strobe and no bus drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 3 | Transfer kind code |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request can be taken this cycle |
| ready_in | input | 1 | External ready, low inserts wait phases |
| bus_in | input | DATA_W | Data read from shared lines |
| bus_out | output | ADDR_W | Value driven onto shared lines |
| bus_oe | output | 1 | Shared lines output enable |
| addr_strobe | output | 1 | Address-latch strobe |
| io_sel | output | 1 | 1 = I/O space, 0 = memory |
| dir_tx | output | 1 | 1 = transmit, 0 = receive |
| den_n | output | 1 | Data enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ack_n | output | 1 | Interrupt-acknowledge strobe, active low |
| rdata | output | DATA_W | Read data or vector |
| done | output | 1 | Cycle completes (phase four) |

## Verification
The bench uses the default widths: 20 address bits and 16 data bits. With these widths the zero-extension of the 8-bit vector into the upper data byte can be observed. So can the address bits above the data field that stay on the lines during a write. Random runs cover wait counts from zero to four, idle gaps and back-to-back cycles. Directed cases cover the illegal kind codes and an acknowledge whose bus input has a non-zero upper byte.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_TW   = 3'd3,
    PH_T3   = 3'd4,
    PH_T4   = 3'd5
  } phase_t;

  localparam logic [2:0] KIND_MEM_RD = 3'd0;
  localparam logic [2:0] KIND_MEM_WR = 3'd1;
  localparam logic [2:0] KIND_IO_RD  = 3'd2;
  localparam logic [2:0] KIND_IO_WR  = 3'd3;
  localparam logic [2:0] KIND_ACK    = 3'd4;

  typedef struct packed {
    logic wr;
    logic io;
    logic ack;
  } xfer_attr_t;

  localparam int VEC_W = 8;
endpackage

// File: rtl/mbus_kind_decode.sv
module mbus_kind_decode
  import mbus_pkg::*;
(
  input  logic [2:0]  kind,
  output logic        legal,
  output xfer_attr_t  attr
);
  always_comb begin
    legal = 1'b1;
    attr  = '0;
    case (kind)
      KIND_MEM_RD: attr = '{wr: 1'b0, io: 1'b0, ack: 1'b0};
      KIND_MEM_WR: attr = '{wr: 1'b1, io: 1'b0, ack: 1'b0};
      KIND_IO_RD:  attr = '{wr: 1'b0, io: 1'b1, ack: 1'b0};
      KIND_IO_WR:  attr = '{wr: 1'b1, io: 1'b1, ack: 1'b0};
      KIND_ACK:    attr = '{wr: 1'b0, io: 1'b0, ack: 1'b1};
      default:     legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbus_phase_fsm.sv
module mbus_phase_fsm
  import mbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   legal,
  input  logic   ready_in,
  output phase_t phase_q,
  output phase_t phase_d,
  output logic   accept,
  output logic   req_ready
);
  assign req_ready = (phase_q == PH_IDLE) || (phase_q == PH_T4);
  assign accept    = req_valid && legal && req_ready;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE: phase_d = accept ? PH_T1 : PH_IDLE;
      PH_T1:   phase_d = PH_T2;
      PH_T2:   phase_d = ready_in ? PH_T3 : PH_TW;
      PH_TW:   phase_d = ready_in ? PH_T3 : PH_TW;
      PH_T3:   phase_d = PH_T4;
      PH_T4:   phase_d = accept ? PH_T1 : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_d;
  end

  // R5: a low ready sample at the end of T2 or of a wait leads to a wait phase
  assert_wait_on_low_R5: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_T2 || phase_q == PH_TW) && !ready_in) |=> (phase_q == PH_TW));

  // R9: a request taken in T4 starts T1 at once
  assert_chain_from_t4_R9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_T4 && accept) |=> (phase_q == PH_T1));
endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase_q,
  input  phase_t            phase_d,
  input  logic              accept,
  input  xfer_attr_t        attr_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              addr_strobe,
  output logic              io_sel,
  output logic              dir_tx,
  output logic              den_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ack_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  localparam int UP_W = ADDR_W - DATA_W;

  xfer_attr_t        attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  xfer_attr_t        attr_n;
  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] wdata_n;
  logic              busy_n, strobe_on, data_ph;
  logic [DATA_W-1:0] vec_ext;

  assign attr_n  = accept ? attr_in  : attr_q;
  assign addr_n  = accept ? addr_in  : addr_q;
  assign wdata_n = accept ? wdata_in : wdata_q;

  assign busy_n    = (phase_d != PH_IDLE);
  assign strobe_on = (phase_d == PH_T2) || (phase_d == PH_TW) || (phase_d == PH_T3);
  assign data_ph   = strobe_on || (phase_d == PH_T4);

  generate
    if (DATA_W > VEC_W) begin : g_vec_pad
      assign vec_ext = {{(DATA_W-VEC_W){1'b0}}, bus_in[VEC_W-1:0]};
    end else begin : g_vec_full
      assign vec_ext = bus_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q      <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      bus_out     <= '0;
      bus_oe      <= 1'b0;
      addr_strobe <= 1'b0;
      io_sel      <= 1'b0;
      dir_tx      <= 1'b0;
      den_n       <= 1'b1;
      rd_n        <= 1'b1;
      wr_n        <= 1'b1;
      ack_n       <= 1'b1;
      rdata       <= '0;
      done        <= 1'b0;
    end else begin
      if (accept) begin
        attr_q  <= attr_in;
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
      end
      addr_strobe <= (phase_d == PH_T1);
      io_sel      <= busy_n && attr_n.io;
      dir_tx      <= busy_n && attr_n.wr;
      den_n       <= !strobe_on;
      rd_n        <= !(strobe_on && !attr_n.wr && !attr_n.ack);
      wr_n        <= !(strobe_on && attr_n.wr);
      ack_n       <= !(strobe_on && attr_n.ack);
      done        <= (phase_d == PH_T4);
      if (phase_d == PH_T1 && !attr_n.ack) begin
        bus_oe  <= 1'b1;
        bus_out <= addr_n;
      end else if (data_ph && attr_n.wr) begin
        bus_oe  <= 1'b1;
        bus_out <= {addr_n[ADDR_W-1 -: UP_W], wdata_n};
      end else begin
        bus_oe  <= 1'b0;
        bus_out <= '0;
      end
      if (phase_q == PH_T3 && !attr_q.wr)
        rdata <= attr_q.ack ? vec_ext : bus_in;
    end
  end

  // R4: never more than one command strobe active
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $countones({~rd_n, ~wr_n, ~ack_n}) <= 1);

  // R2: address phase carries no command strobe
  assert_strobe_idle_in_addr_R2: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> (rd_n && wr_n && ack_n && den_n));

  // R7: completion clock releases strobes and lasts one clock
  assert_release_at_done_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && ack_n && den_n));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: acknowledge never drives the shared lines
  assert_ack_float_R8: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> !bus_oe);

  // R3: direction and space select hold while data is enabled
  assert_dir_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !den_n |=> ($stable(dir_tx) && $stable(io_sel)));
endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              addr_strobe,
  output logic              io_sel,
  output logic              dir_tx,
  output logic              den_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              ack_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic       legal, accept;
  xfer_attr_t attr;
  phase_t     phase_q, phase_d;

  mbus_kind_decode u_dec (
    .kind  (req_kind),
    .legal (legal),
    .attr  (attr)
  );

  mbus_phase_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .legal     (legal),
    .ready_in  (ready_in),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .accept    (accept),
    .req_ready (req_ready)
  );

  mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .phase_q     (phase_q),
    .phase_d     (phase_d),
    .accept      (accept),
    .attr_in     (attr),
    .addr_in     (req_addr),
    .wdata_in    (req_wdata),
    .bus_in      (bus_in),
    .bus_out     (bus_out),
    .bus_oe      (bus_oe),
    .addr_strobe (addr_strobe),
    .io_sel      (io_sel),
    .dir_tx      (dir_tx),
    .den_n       (den_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ack_n       (ack_n),
    .rdata       (rdata),
    .done        (done)
  );

  // R10: an illegal kind while idle leaves the block idle
  assert_illegal_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !legal && phase_q == PH_IDLE) |=> (phase_q == PH_IDLE));
endmodule

// File: tb/mbus_cycle_seq_bench.sv
`timescale 1ns/1ps
module mbus_cycle_seq_bench;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [2:0]    req_kind = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          ready_in = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [AW-1:0] bus_out;
  logic          bus_oe, addr_strobe, io_sel, dir_tx, den_n, rd_n, wr_n, ack_n, done;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mbus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW)) u_mbus_cycle_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .ready_in(ready_in), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .addr_strobe(addr_strobe), .io_sel(io_sel), .dir_tx(dir_tx), .den_n(den_n),
    .rd_n(rd_n), .wr_n(wr_n), .ack_n(ack_n), .rdata(rdata), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [2:0] k, input logic [DW-1:0] d);
    return (k == 3'd4) ? {8'h00, d[7:0]} : d;
  endfunction

  // Runs one cycle; entered and left at a negedge where req_ready should be 1.
  task automatic run_xfer(input logic [2:0] k, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input int nw, input logic [DW-1:0] din);
    bit is_wr, is_io, is_ack;
    is_wr  = (k == 3'd1) || (k == 3'd3);
    is_io  = (k == 3'd2) || (k == 3'd3);
    is_ack = (k == 3'd4);
    chk_eq("R9 req_ready before request", req_ready, 1);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = wd; bus_in = din;
    @(negedge clk);
    req_valid = 1'b0;
    // phase one
    chk_eq("R2 addr_strobe in T1", addr_strobe, 1);
    chk_eq("R2 strobes high in T1", {rd_n, wr_n, ack_n, den_n}, 4'hF);
    chk_eq("R8 R2 bus_oe in T1", bus_oe, !is_ack);
    if (!is_ack) chk_eq("R2 address on bus", bus_out, a);
    chk_eq("R3 io_sel", io_sel, is_io);
    chk_eq("R3 dir_tx", dir_tx, is_wr);
    chk_eq("R9 req_ready low in T1", req_ready, 0);
    @(negedge clk);
    // phase two
    chk_eq("R4 addr_strobe off in T2", addr_strobe, 0);
    chk_eq("R4 den_n low in T2", den_n, 0);
    chk_eq("R4 strobe select", {rd_n, wr_n, ack_n},
           {!(!is_wr && !is_ack), !is_wr, !is_ack});
    chk_eq("R4 R8 bus_oe in T2", bus_oe, is_wr);
    if (is_wr) chk_eq("R4 write data on bus", bus_out, {a[AW-1:DW], wd});
    ready_in = (nw == 0);
    for (int w = 0; w < nw; w++) begin
      @(negedge clk);
      chk_eq("R5 no done during wait", done, 0);
      chk_eq("R5 den_n held in wait", den_n, 0);
      chk_eq("R3 dir held in wait", dir_tx, is_wr);
      ready_in = (w == nw - 1);
    end
    @(negedge clk);
    // phase three
    chk_eq("R5 no done in T3", done, 0);
    chk_eq("R5 strobe still active in T3", rd_n & wr_n & ack_n, 0);
    ready_in = 1'b1;
    @(negedge clk);
    // phase four
    chk_eq("R7 R5 done in T4", done, 1);
    chk_eq("R7 strobes released in T4", {rd_n, wr_n, ack_n, den_n}, 4'hF);
    chk_eq("R3 io_sel in T4", io_sel, is_io);
    if (!is_wr) chk_eq("R6 R8 rdata", rdata, exp_read(k, din));
    bus_in = ~din;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    chk_eq("R9 idle after cycle, no done", done, 0);
    chk_eq("R9 req_ready in idle", req_ready, 1);
    chk_eq("R9 no strobe in idle", addr_strobe, 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_eq("R1 addr_strobe", addr_strobe, 0);
    chk_eq("R1 strobes", {rd_n, wr_n, ack_n, den_n}, 4'hF);
    chk_eq("R1 bus_oe", bus_oe, 0);
    chk_eq("R1 done", done, 0);
    chk_eq("R1 req_ready", req_ready, 1);

    // directed
    run_xfer(3'd0, 20'hABCDE, 16'h1111, 0, 16'h5A3C);
    idle_cycle();
    run_xfer(3'd1, 20'hF0123, 16'hBEEF, 3, 16'h0000);
    run_xfer(3'd2, 20'h003F8, 16'h0000, 1, 16'hC001);   // back to back R9
    idle_cycle();
    run_xfer(3'd3, 20'h00060, 16'h00A5, 0, 16'h0000);
    idle_cycle();
    run_xfer(3'd4, 20'h00000, 16'h0000, 2, 16'hFF21);   // R8 upper byte dropped
    idle_cycle();

    // R10 illegal kinds
    for (int k = 5; k < 8; k++) begin
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 20'h12345;
      @(negedge clk);
      req_valid = 1'b0;
      chk_eq("R10 no address strobe", addr_strobe, 0);
      chk_eq("R10 no bus drive", bus_oe, 0);
      chk_eq("R10 still ready", req_ready, 1);
      @(negedge clk);
      chk_eq("R10 no strobe later", {rd_n, wr_n, ack_n, den_n}, 4'hF);
    end

    // random
    for (int i = 0; i < 300; i++) begin
      run_xfer(3'($urandom % 5), 20'($urandom), 16'($urandom),
               int'($urandom % 5), 16'($urandom));
      if ($urandom % 2 == 0) idle_cycle();
    end
    idle_cycle();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule